// File: doc/BRIEF.md
# Load-Use Interlock and Operand Forwarding Control

This block is the hazard controller of an in-order five-stage integer pipeline. Each cycle it picks the source of both ALU operands for the instruction in the execute stage. The choice is made by comparing that instruction's source register numbers against the destinations of the instructions in the memory and writeback stages. The second operand can also take an immediate.

It also keeps one reservation bit per architectural register. A load sets the bit for its destination when it leaves decode. The bit is cleared when the load leaves execute. A decoding instruction that reads a reserved register raises `stall_o`. The pipeline uses that signal to hold its fetch and decode registers and to push a no-op with its write enable cleared into execute. A load followed at once by a consumer therefore costs exactly one bubble. The loaded value then reaches the consumer over the writeback forwarding path.

Top module: `hz_ctrl`

## Requirements
- R1: `op_b_sel_o` is 3 (immediate) whenever `ex_use_imm_i` is high, whatever the register matches.
- R2: Without an immediate, an operand whose source register is nonzero and equals `mem_rd_i` while `mem_we_i` is high selects 1 (memory-stage result). This takes priority over a writeback match.
- R3: Otherwise, a nonzero source register equal to `wb_rd_i` while `wb_we_i` is high selects 2 (writeback result). Failing all matches, the selection is 0 (register file).
- R4: `op_a_sel_o` follows the same memory-over-writeback-over-file priority and never takes the value 3.
- R5: A source register of 0 is never forwarded; its selection is 0 unless R1 applies.
- R6: A load in decode (`id_is_load_i`) that is not stalled reserves `id_rd_i` at the clock edge. A decoding instruction that reads a reserved register through an enabled port (`id_rs1_en_i`/`id_rs2_en_i`) raises `stall_o` combinationally.
- R7: The reservation of `ex_rd_i` clears at the edge where `ex_is_load_i` is high. A consumer placed right behind a load therefore stalls for exactly one cycle. A consumer two instructions behind does not stall.
- R8: A load held in decode by `stall_o` reserves nothing until it advances.
- R9: Register 0 is never reserved, and a read of register 0 never stalls.
- R10: Only loads reserve. A non-load in decode leaves every register free. Reset clears all reservations.
- R11: A source read through a disabled port never causes a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| id_rs1_i | input | 5 | Decode-stage first source register |
| id_rs1_en_i | input | 1 | Decode-stage first source is read |
| id_rs2_i | input | 5 | Decode-stage second source register |
| id_rs2_en_i | input | 1 | Decode-stage second source is read |
| id_rd_i | input | 5 | Decode-stage destination register |
| id_is_load_i | input | 1 | Decode-stage instruction is a load |
| ex_rs1_i | input | 5 | Execute-stage first source register |
| ex_rs2_i | input | 5 | Execute-stage second source register |
| ex_use_imm_i | input | 1 | Execute-stage instruction takes an immediate as operand B |
| ex_rd_i | input | 5 | Execute-stage destination register |
| ex_is_load_i | input | 1 | Execute-stage instruction is a load |
| mem_rd_i | input | 5 | Memory-stage destination register |
| mem_we_i | input | 1 | Memory-stage register write enable |
| wb_rd_i | input | 5 | Writeback-stage destination register |
| wb_we_i | input | 1 | Writeback-stage register write enable |
| op_a_sel_o | output | 2 | Operand A source: 0 file, 1 memory, 2 writeback |
| op_b_sel_o | output | 2 | Operand B source: 0 file, 1 memory, 2 writeback, 3 immediate |
| stall_o | output | 1 | Hold fetch/decode and insert a bubble into execute |

## Verification
The bench sets memory and writeback matches on the same register to catch a reversed priority, which would hand the consumer the older writeback value. It raises an immediate during a live match to catch a register value overriding the immediate. It drives register 0 as a destination and as a load target. A design that treated register 0 as ordinary would forward stale data or stall forever. Load-use sequences check that the stall lasts one cycle and not zero or two. They also check that a load held in decode does not reserve early, and that a consumer two slots behind the load runs without a stall.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    OPSEL_RF  = 2'd0,
    OPSEL_MEM = 2'd1,
    OPSEL_WB  = 2'd2,
    OPSEL_IMM = 2'd3
  } opsel_e;
endpackage

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel #(
  parameter int AW      = 5,
  parameter bit HAS_IMM = 1'b0
) (
  input  logic [AW-1:0] rs_i,
  input  logic          use_imm_i,
  input  logic [AW-1:0] mem_rd_i,
  input  logic          mem_we_i,
  input  logic [AW-1:0] wb_rd_i,
  input  logic          wb_we_i,
  output logic [1:0]    sel_o
);
  import hz_pkg::*;

  logic rs_nz, hit_mem, hit_wb, imm_take;
  opsel_e sel;

  assign rs_nz   = (rs_i != '0);
  assign hit_mem = rs_nz && mem_we_i && (mem_rd_i == rs_i);
  assign hit_wb  = rs_nz && wb_we_i && (wb_rd_i == rs_i);

  generate
    if (HAS_IMM) begin : g_imm
      assign imm_take = use_imm_i;
    end else begin : g_noimm
      logic unused_imm;
      assign unused_imm = use_imm_i;
      assign imm_take   = 1'b0;
    end
  endgenerate

  always_comb begin
    if (imm_take)     sel = OPSEL_IMM;
    else if (hit_mem) sel = OPSEL_MEM;
    else if (hit_wb)  sel = OPSEL_WB;
    else              sel = OPSEL_RF;
  end

  assign sel_o = sel;
endmodule

// File: rtl/hz_scoreboard.sv
module hz_scoreboard #(
  parameter int NREGS = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_en_i,
  input  logic [AW-1:0]    set_rd_i,
  input  logic             clr_en_i,
  input  logic [AW-1:0]    clr_rd_i,
  output logic [NREGS-1:0] busy_o
);
  generate
    for (genvar g = 0; g < NREGS; g++) begin : g_bit
      if (g == 0) begin : g_zero
        assign busy_o[g] = 1'b0;
      end else begin : g_reg
        logic busy_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni)                                   busy_q <= 1'b0;
          else if (set_en_i && set_rd_i == AW'(g))       busy_q <= 1'b1; // newer load wins
          else if (clr_en_i && clr_rd_i == AW'(g))       busy_q <= 1'b0;
        end
        assign busy_o[g] = busy_q;
      end
    end
  endgenerate
endmodule

// File: rtl/hz_load_stall.sv
module hz_load_stall #(
  parameter int NREGS = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic [NREGS-1:0] busy_i,
  input  logic [AW-1:0]    rs1_i,
  input  logic             rs1_en_i,
  input  logic [AW-1:0]    rs2_i,
  input  logic             rs2_en_i,
  output logic             stall_o
);
  assign stall_o = (rs1_en_i && busy_i[rs1_i]) || (rs2_en_i && busy_i[rs2_i]);
endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl #(
  parameter int NREGS = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] id_rs1_i,
  input  logic          id_rs1_en_i,
  input  logic [AW-1:0] id_rs2_i,
  input  logic          id_rs2_en_i,
  input  logic [AW-1:0] id_rd_i,
  input  logic          id_is_load_i,
  input  logic [AW-1:0] ex_rs1_i,
  input  logic [AW-1:0] ex_rs2_i,
  input  logic          ex_use_imm_i,
  input  logic [AW-1:0] ex_rd_i,
  input  logic          ex_is_load_i,
  input  logic [AW-1:0] mem_rd_i,
  input  logic          mem_we_i,
  input  logic [AW-1:0] wb_rd_i,
  input  logic          wb_we_i,
  output logic [1:0]    op_a_sel_o,
  output logic [1:0]    op_b_sel_o,
  output logic          stall_o
);
  logic [NREGS-1:0] busy;
  logic             stall;
  logic             rsv_set;

  // a held load reserves only once it advances
  assign rsv_set = id_is_load_i && !stall;

  hz_fwd_sel #(.AW(AW), .HAS_IMM(1'b0)) u_sel_a (
    .rs_i      (ex_rs1_i),
    .use_imm_i (1'b0),
    .mem_rd_i  (mem_rd_i),
    .mem_we_i  (mem_we_i),
    .wb_rd_i   (wb_rd_i),
    .wb_we_i   (wb_we_i),
    .sel_o     (op_a_sel_o)
  );

  hz_fwd_sel #(.AW(AW), .HAS_IMM(1'b1)) u_sel_b (
    .rs_i      (ex_rs2_i),
    .use_imm_i (ex_use_imm_i),
    .mem_rd_i  (mem_rd_i),
    .mem_we_i  (mem_we_i),
    .wb_rd_i   (wb_rd_i),
    .wb_we_i   (wb_we_i),
    .sel_o     (op_b_sel_o)
  );

  hz_scoreboard #(.NREGS(NREGS)) u_sb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_en_i (rsv_set),
    .set_rd_i (id_rd_i),
    .clr_en_i (ex_is_load_i),
    .clr_rd_i (ex_rd_i),
    .busy_o   (busy)
  );

  hz_load_stall #(.NREGS(NREGS)) u_stall (
    .busy_i   (busy),
    .rs1_i    (id_rs1_i),
    .rs1_en_i (id_rs1_en_i),
    .rs2_i    (id_rs2_i),
    .rs2_en_i (id_rs2_en_i),
    .stall_o  (stall)
  );

  assign stall_o = stall;
endmodule

// File: rtl/hz_ctrl_chk.sv
module hz_ctrl_chk #(
  parameter int NREGS = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] id_rs1_i,
  input logic          id_rs1_en_i,
  input logic [AW-1:0] id_rs2_i,
  input logic          id_rs2_en_i,
  input logic [AW-1:0] id_rd_i,
  input logic          id_is_load_i,
  input logic [AW-1:0] ex_rs2_i,
  input logic          ex_use_imm_i,
  input logic [AW-1:0] mem_rd_i,
  input logic          mem_we_i,
  input logic [1:0]    op_a_sel_o,
  input logic [1:0]    op_b_sel_o,
  input logic          stall_o
);
  a_r1_imm_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ex_use_imm_i |-> op_b_sel_o == 2'd3);

  a_r2_mem_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ex_use_imm_i && mem_we_i && ex_rs2_i != '0 && mem_rd_i == ex_rs2_i) |-> op_b_sel_o == 2'd1);

  a_r4_a_no_imm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_a_sel_o != 2'd3);

  a_r6_load_use_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(id_is_load_i && !stall_o && id_rd_i != '0) && id_rs1_en_i && id_rs1_i == $past(id_rd_i))
      |-> stall_o);

  a_r9_r0_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_rs1_i == '0 && id_rs2_i == '0) |-> !stall_o);

  a_r11_no_read_no_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!id_rs1_en_i && !id_rs2_en_i) |-> !stall_o);
endmodule

bind hz_ctrl hz_ctrl_chk #(.NREGS(NREGS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .id_rs1_i     (id_rs1_i),
  .id_rs1_en_i  (id_rs1_en_i),
  .id_rs2_i     (id_rs2_i),
  .id_rs2_en_i  (id_rs2_en_i),
  .id_rd_i      (id_rd_i),
  .id_is_load_i (id_is_load_i),
  .ex_rs2_i     (ex_rs2_i),
  .ex_use_imm_i (ex_use_imm_i),
  .mem_rd_i     (mem_rd_i),
  .mem_we_i     (mem_we_i),
  .op_a_sel_o   (op_a_sel_o),
  .op_b_sel_o   (op_b_sel_o),
  .stall_o      (stall_o)
);

// File: tb/hz_ctrl_bench.sv
module hz_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [4:0] id_rs1_i = '0, id_rs2_i = '0, id_rd_i = '0;
  logic       id_rs1_en_i = 1'b0, id_rs2_en_i = 1'b0, id_is_load_i = 1'b0;
  logic [4:0] ex_rs1_i = '0, ex_rs2_i = '0, ex_rd_i = '0;
  logic       ex_use_imm_i = 1'b0, ex_is_load_i = 1'b0;
  logic [4:0] mem_rd_i = '0, wb_rd_i = '0;
  logic       mem_we_i = 1'b0, wb_we_i = 1'b0;
  logic [1:0] op_a_sel_o, op_b_sel_o;
  logic       stall_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  hz_ctrl u_hz_ctrl (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    id_rs1_i = '0; id_rs2_i = '0; id_rd_i = '0;
    id_rs1_en_i = 0; id_rs2_en_i = 0; id_is_load_i = 0;
    ex_rs1_i = '0; ex_rs2_i = '0; ex_rd_i = '0; ex_use_imm_i = 0; ex_is_load_i = 0;
    mem_rd_i = '0; mem_we_i = 0; wb_rd_i = '0; wb_we_i = 0;
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    idle();
    for (int r = 1; r < 32; r++) begin
      id_rs1_i = 5'(r); id_rs1_en_i = 1; #1;
      if (stall_o) chk("R10 reset reservation", r, 0);
    end
    chk("R10 reset stall", int'(stall_o), 0);
    chk("R3 reset sel_a", int'(op_a_sel_o), 0);
    idle();
  endtask

  task automatic t_imm();
    idle();
    ex_rs2_i = 5'd7; mem_rd_i = 5'd7; mem_we_i = 1; ex_use_imm_i = 1; #1;
    chk("R1 imm over mem", int'(op_b_sel_o), 3);
    ex_use_imm_i = 0; #1;
    chk("R2 mem when no imm", int'(op_b_sel_o), 1);
    idle();
  endtask

  task automatic t_prio();
    idle();
    ex_rs1_i = 5'd9; ex_rs2_i = 5'd9;
    mem_rd_i = 5'd9; mem_we_i = 1; wb_rd_i = 5'd9; wb_we_i = 1; #1;
    chk("R2 mem over wb (b)", int'(op_b_sel_o), 1);
    chk("R4 mem over wb (a)", int'(op_a_sel_o), 1);
    mem_we_i = 0; #1;
    chk("R3 wb when mem disabled", int'(op_b_sel_o), 2);
    chk("R4 wb a", int'(op_a_sel_o), 2);
    wb_we_i = 0; #1;
    chk("R3 rf fallback", int'(op_b_sel_o), 0);
    mem_we_i = 1; mem_rd_i = 5'd4; wb_we_i = 1; wb_rd_i = 5'd9; #1;
    chk("R3 wb on mismatch mem", int'(op_a_sel_o), 2);
    ex_use_imm_i = 1; #1;
    chk("R4 a ignores imm", int'(op_a_sel_o), 2);
    idle();
  endtask

  task automatic t_r0();
    idle();
    mem_rd_i = 0; mem_we_i = 1; wb_rd_i = 0; wb_we_i = 1; #1;
    chk("R5 r0 a", int'(op_a_sel_o), 0);
    chk("R5 r0 b", int'(op_b_sel_o), 0);
    idle();
    id_is_load_i = 1; id_rd_i = 0; step();
    id_is_load_i = 0; id_rs1_i = 0; id_rs1_en_i = 1; id_rs2_en_i = 1; #1;
    chk("R9 r0 not reserved", int'(stall_o), 0);
    idle();
  endtask

  task automatic t_load_use();
    idle();
    id_is_load_i = 1; id_rd_i = 5'd5; #1;
    chk("R6 load itself no stall", int'(stall_o), 0);
    step();
    id_is_load_i = 0; id_rs1_i = 5'd5; id_rs1_en_i = 1;
    ex_is_load_i = 1; ex_rd_i = 5'd5; #1;
    chk("R6 consumer stalls", int'(stall_o), 1);
    step();
    ex_is_load_i = 0; ex_rd_i = 0; mem_rd_i = 5'd5; mem_we_i = 1; #1;
    chk("R7 single bubble", int'(stall_o), 0);
    step();
    idle();
    ex_rs1_i = 5'd5; wb_rd_i = 5'd5; wb_we_i = 1; #1;
    chk("R7 forward from wb after bubble", int'(op_a_sel_o), 2);
    idle();
  endtask

  task automatic t_rs2_and_enable();
    idle();
    id_is_load_i = 1; id_rd_i = 5'd12; step();
    id_is_load_i = 0; id_rd_i = 0; id_rs2_i = 5'd12; id_rs2_en_i = 0;
    id_rs1_i = 5'd12; id_rs1_en_i = 0; ex_is_load_i = 1; ex_rd_i = 5'd12; #1;
    chk("R11 disabled ports", int'(stall_o), 0);
    id_rs2_en_i = 1; #1;
    chk("R6 rs2 stall", int'(stall_o), 1);
    step();
    idle();
    id_rs2_i = 5'd12; id_rs2_en_i = 1; #1;
    chk("R7 cleared after ex", int'(stall_o), 0);
    idle();
  endtask

  task automatic t_gap();
    idle();
    id_is_load_i = 1; id_rd_i = 5'd8; step();
    id_is_load_i = 0; id_rd_i = 5'd3; ex_is_load_i = 1; ex_rd_i = 5'd8; #1;
    chk("R7 unrelated follower", int'(stall_o), 0);
    step();
    idle();
    id_rs1_i = 5'd8; id_rs1_en_i = 1; #1;
    chk("R7 consumer two behind", int'(stall_o), 0);
    idle();
  endtask

  task automatic t_nonload();
    idle();
    id_rd_i = 5'd14; step();
    id_rd_i = 0; id_rs1_i = 5'd14; id_rs1_en_i = 1; #1;
    chk("R10 non-load no reserve", int'(stall_o), 0);
    idle();
  endtask

  task automatic t_held_load();
    idle();
    id_is_load_i = 1; id_rd_i = 5'd20; step();
    // held load to r21 reads r20
    id_rd_i = 5'd21; id_rs1_i = 5'd20; id_rs1_en_i = 1;
    ex_is_load_i = 1; ex_rd_i = 5'd20; #1;
    chk("R6 held load stalls", int'(stall_o), 1);
    step();
    id_is_load_i = 0; id_rd_i = 0; id_rs1_i = 5'd21; id_rs1_en_i = 1;
    ex_is_load_i = 0; ex_rd_i = 0; #1;
    chk("R8 held load reserved nothing", int'(stall_o), 0);
    idle();
  endtask

  initial begin
    idle();
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_imm();
    t_prio();
    t_r0();
    t_load_use();
    t_rs2_and_enable();
    t_gap();
    t_nonload();
    t_held_load();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule